// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block takes a DDR SDRAM device from a freshly powered, clocked state to a state where it can accept normal traffic. After one start pulse it drives the command bus through a fixed program. First it waits for the settle time. Next comes a precharge of every bank, then an extended mode write that turns the DLL on. A mode write follows that loads the operating fields and resets the DLL, then a second precharge of every bank and two auto-refresh commands. A final mode write loads the same fields with the DLL reset bit cleared. When the program is finished, a sticky done flag rises.

Every wait is a parameter counted in clock cycles: the settle wait, the precharge time, the mode-write gap, the refresh cycle time and the DLL lock time. The burst length code, the burst type bit and the CAS latency code that go into the mode register are also parameters. The lock time is measured from the mode write that resets the DLL. The done flag does not rise until that time has passed, so a controller can gate reads on it. All pins come from registers, and every cycle without a command carries a NOP.

Top module: `ddr_pwrup_seq`

## Requirements
- R1: While reset is asserted, and afterwards until a start pulse is taken, the block holds CKE low, drives a deselect (CS# high with RAS#, CAS# and WE# high), drives BA and A to zero and holds done low.
- R2: A start pulse sampled in the idle state raises CKE at that clock edge and begins the settle wait. The edge that samples start is counted as offset 0. A NOP appears for offsets 0 to SETTLE_CYC-1, and the first precharge-all (CS#,RAS#,CAS#,WE# = 0,0,1,0 with A10 = 1, BA = 0, other A bits 0) appears at offset SETTLE_CYC.
- R3: The commands issued are exactly seven, in this order: precharge-all, extended mode write, mode write with DLL reset, precharge-all, auto-refresh, auto-refresh, mode write without DLL reset.
- R4: A command after a precharge-all follows it by exactly TRP_CYC edges. A command after a mode write or extended mode write follows it by exactly TMRD_CYC edges (TMRD_CYC is at least 2).
- R5: An auto-refresh (0,0,0,1; BA and A zero) is followed by exactly TRFC_CYC edges before the next command, both after the first refresh and after the second.
- R6: The extended mode write (0,0,0,0) carries BA = 01 and A = 0, so A0 = 0 enables the DLL and all reserved bits are zero.
- R7: Both mode writes (0,0,0,0) carry BA = 00, A[2:0] = MR_BL, A[3] = MR_BT, A[6:4] = MR_CL, A[8] = DLL reset (1 on the first, 0 on the last) and zeros in A[7] and A[11:9].
- R8: From the start edge on, CKE stays high and every cycle without one of the seven commands carries a NOP (0,1,1,1 with BA and A zero), including the cycles after done.
- R9: Done rises at the later of two edges: TMRD_CYC edges after the final mode write, and DLL_LOCK_CYC edges after the DLL-reset mode write. It then stays high until reset.
- R10: A start pulse during the program or after done has no effect on the command stream or on when done rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all state changes on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle pulse that launches the program from idle |
| done_o | output | 1 | High once the device is initialized; sticky until reset |
| cke_o | output | 1 | Clock enable to the device |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | 2 | Bank address; selects mode (00) or extended mode (01) register |
| addr_o | output | 12 | Address bus; carries register contents and the A10 all-bank flag |

## Verification
The hardest case to reach is the choice that sets when done rises. With realistic settings the DLL lock time outlasts the rest of the program, so the branch where done follows the final mode-write gap never runs. The bench drives a second instance with a short settle wait, a lock time of a few cycles and different mode fields. Both instances see the same start pulses, including one pulse in mid-program, one after done, and a reset that cuts a running program short. Each instance has its own behavioural timeline, and both are compared with their timelines on every clock.

// File: rtl/ddr_pwrup_pkg.sv
package ddr_pwrup_pkg;

  localparam int BA_W   = 2;
  localparam int ADDR_W = 12;

  typedef enum logic [2:0] {
    CMD_DESEL,
    CMD_NOP,
    CMD_PREA,
    CMD_AREF,
    CMD_MRS,
    CMD_EMRS
  } cmd_e;

  // Each timed phase names the command most recently issued.
  typedef enum logic [3:0] {
    PH_IDLE,
    PH_SETTLE,
    PH_PRE1,
    PH_EMRS,
    PH_MRS_RST,
    PH_PRE2,
    PH_REF1,
    PH_REF2,
    PH_MRS_RUN,
    PH_LOCK,
    PH_DONE
  } phase_e;

  typedef struct packed {
    logic              cs_n;
    logic              ras_n;
    logic              cas_n;
    logic              we_n;
    logic [BA_W-1:0]   ba;
    logic [ADDR_W-1:0] addr;
  } bus_t;

  localparam bus_t IDLE_BUS = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1,
                                ba: '0, addr: '0};

endpackage

// File: rtl/ddr_pwrup_timer.sv
module ddr_pwrup_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         expired_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - W'(1);
    end
  end

  assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/ddr_pwrup_enc.sv
module ddr_pwrup_enc
  import ddr_pwrup_pkg::*;
#(
  parameter logic [2:0] MR_BL = 3'b010,
  parameter logic       MR_BT = 1'b0,
  parameter logic [2:0] MR_CL = 3'b010
) (
  input  cmd_e cmd_i,
  input  logic dll_rst_i,
  output bus_t bus_o
);

  localparam int A_ALLBANK = 10;
  localparam int A_DLLRST  = 8;

  always_comb begin
    bus_o = IDLE_BUS;
    unique case (cmd_i)
      CMD_DESEL: bus_o = IDLE_BUS;
      CMD_NOP: begin
        bus_o.cs_n = 1'b0;
      end
      CMD_PREA: begin
        bus_o.cs_n  = 1'b0;
        bus_o.ras_n = 1'b0;
        bus_o.we_n  = 1'b0;
        bus_o.addr[A_ALLBANK] = 1'b1;
      end
      CMD_AREF: begin
        bus_o.cs_n  = 1'b0;
        bus_o.ras_n = 1'b0;
        bus_o.cas_n = 1'b0;
      end
      CMD_MRS: begin
        bus_o.cs_n  = 1'b0;
        bus_o.ras_n = 1'b0;
        bus_o.cas_n = 1'b0;
        bus_o.we_n  = 1'b0;
        bus_o.ba    = 2'b00;
        bus_o.addr[2:0] = MR_BL;
        bus_o.addr[3]   = MR_BT;
        bus_o.addr[6:4] = MR_CL;
        bus_o.addr[A_DLLRST] = dll_rst_i;
      end
      CMD_EMRS: begin
        bus_o.cs_n  = 1'b0;
        bus_o.ras_n = 1'b0;
        bus_o.cas_n = 1'b0;
        bus_o.we_n  = 1'b0;
        bus_o.ba    = 2'b01;
      end
      default: bus_o = IDLE_BUS;
    endcase
  end

endmodule

// File: rtl/ddr_pwrup_seq.sv
module ddr_pwrup_seq
  import ddr_pwrup_pkg::*;
#(
  parameter int         SETTLE_CYC   = 40,
  parameter int         TRP_CYC      = 3,
  parameter int         TMRD_CYC     = 2,
  parameter int         TRFC_CYC     = 12,
  parameter int         DLL_LOCK_CYC = 200,
  parameter logic [2:0] MR_BL        = 3'b010,
  parameter logic       MR_BT        = 1'b0,
  parameter logic [2:0] MR_CL        = 3'b010
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  output logic        done_o,
  output logic        cke_o,
  output logic        cs_n_o,
  output logic        ras_n_o,
  output logic        cas_n_o,
  output logic        we_n_o,
  output logic [1:0]  ba_o,
  output logic [11:0] addr_o
);

  localparam int MAX_A    = (SETTLE_CYC > TRP_CYC) ? SETTLE_CYC : TRP_CYC;
  localparam int MAX_B    = (TMRD_CYC > TRFC_CYC) ? TMRD_CYC : TRFC_CYC;
  localparam int STEP_MAX = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int STEP_W   = $clog2(STEP_MAX + 1);
  localparam int LOCK_W   = $clog2(DLL_LOCK_CYC + 1);

  phase_e phase_q, phase_d;
  logic   done_q, done_d;
  logic   cke_q, cke_d;
  bus_t   bus_q, bus_d;
  cmd_e   cmd_d;
  logic   dll_rst_d;

  logic              step_load, step_exp;
  logic [STEP_W-1:0] step_val;
  logic              lock_load, lock_exp;

  ddr_pwrup_timer #(.W(STEP_W)) u_step_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (step_load),
    .load_val_i (step_val),
    .expired_o  (step_exp)
  );

  ddr_pwrup_timer #(.W(LOCK_W)) u_lock_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (lock_load),
    .load_val_i (LOCK_W'(DLL_LOCK_CYC - 1)),
    .expired_o  (lock_exp)
  );

  ddr_pwrup_enc #(.MR_BL(MR_BL), .MR_BT(MR_BT), .MR_CL(MR_CL)) u_enc (
    .cmd_i     (cmd_d),
    .dll_rst_i (dll_rst_d),
    .bus_o     (bus_d)
  );

  always_comb begin
    phase_d   = phase_q;
    done_d    = done_q;
    cke_d     = cke_q;
    cmd_d     = CMD_NOP;
    dll_rst_d = 1'b0;
    step_load = 1'b0;
    step_val  = '0;
    lock_load = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        cmd_d = CMD_DESEL;
        if (start_i) begin
          phase_d   = PH_SETTLE;
          cke_d     = 1'b1;
          cmd_d     = CMD_NOP;
          step_load = 1'b1;
          step_val  = STEP_W'(SETTLE_CYC - 1);
        end
      end
      PH_LOCK: begin
        if (lock_exp) begin
          done_d  = 1'b1;
          phase_d = PH_DONE;
        end
      end
      PH_DONE: ;
      default: begin
        if (step_exp) begin
          unique case (phase_q)
            PH_SETTLE: begin
              phase_d   = PH_PRE1;
              cmd_d     = CMD_PREA;
              step_load = 1'b1;
              step_val  = STEP_W'(TRP_CYC - 1);
            end
            PH_PRE1: begin
              phase_d   = PH_EMRS;
              cmd_d     = CMD_EMRS;
              step_load = 1'b1;
              step_val  = STEP_W'(TMRD_CYC - 1);
            end
            PH_EMRS: begin
              phase_d   = PH_MRS_RST;
              cmd_d     = CMD_MRS;
              dll_rst_d = 1'b1;
              lock_load = 1'b1;
              step_load = 1'b1;
              step_val  = STEP_W'(TMRD_CYC - 1);
            end
            PH_MRS_RST: begin
              phase_d   = PH_PRE2;
              cmd_d     = CMD_PREA;
              step_load = 1'b1;
              step_val  = STEP_W'(TRP_CYC - 1);
            end
            PH_PRE2: begin
              phase_d   = PH_REF1;
              cmd_d     = CMD_AREF;
              step_load = 1'b1;
              step_val  = STEP_W'(TRFC_CYC - 1);
            end
            PH_REF1: begin
              phase_d   = PH_REF2;
              cmd_d     = CMD_AREF;
              step_load = 1'b1;
              step_val  = STEP_W'(TRFC_CYC - 1);
            end
            PH_REF2: begin
              phase_d   = PH_MRS_RUN;
              cmd_d     = CMD_MRS;
              step_load = 1'b1;
              step_val  = STEP_W'(TMRD_CYC - 1);
            end
            PH_MRS_RUN: begin
              if (lock_exp) begin
                done_d  = 1'b1;
                phase_d = PH_DONE;
              end else begin
                phase_d = PH_LOCK;
              end
            end
            default: phase_d = PH_IDLE;
          endcase
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      done_q  <= 1'b0;
      cke_q   <= 1'b0;
      bus_q   <= IDLE_BUS;
    end else begin
      phase_q <= phase_d;
      done_q  <= done_d;
      cke_q   <= cke_d;
      bus_q   <= bus_d;
    end
  end

  assign done_o  = done_q;
  assign cke_o   = cke_q;
  assign cs_n_o  = bus_q.cs_n;
  assign ras_n_o = bus_q.ras_n;
  assign cas_n_o = bus_q.cas_n;
  assign we_n_o  = bus_q.we_n;
  assign ba_o    = bus_q.ba;
  assign addr_o  = bus_q.addr;

endmodule

// File: rtl/ddr_pwrup_seq_chk.sv
module ddr_pwrup_seq_chk #(
  parameter logic [2:0] MR_BL = 3'b010,
  parameter logic       MR_BT = 1'b0,
  parameter logic [2:0] MR_CL = 3'b010
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        done_o,
  input logic        cke_o,
  input logic        cs_n_o,
  input logic        ras_n_o,
  input logic        cas_n_o,
  input logic        we_n_o,
  input logic [1:0]  ba_o,
  input logic [11:0] addr_o
);

  logic is_nop, is_mode, is_aref;
  assign is_nop  = !cs_n_o && ras_n_o && cas_n_o && we_n_o;
  assign is_mode = !cs_n_o && !ras_n_o && !cas_n_o && !we_n_o;
  assign is_aref = !cs_n_o && !ras_n_o && !cas_n_o && we_n_o;

  // R1
  idle_deselect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cke_o |-> (cs_n_o && !done_o));

  // R2
  start_nop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cke_o) |-> is_nop);

  // R4
  mode_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_mode |=> is_nop);

  // R5
  refresh_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_aref |=> is_nop);

  // R6
  ext_mode_fields_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_mode && ba_o == 2'b01) |-> (addr_o == 12'd0));

  // R7
  mode_fields_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_mode && ba_o == 2'b00) |->
      (addr_o[11:9] == 3'b000 && !addr_o[7] && addr_o[6:4] == MR_CL &&
       addr_o[3] == MR_BT && addr_o[2:0] == MR_BL));

  // R8
  cke_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_o |=> cke_o);

  // R9
  done_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (done_o && is_nop));

  // R9
  done_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> (cke_o && is_nop));

endmodule

bind ddr_pwrup_seq ddr_pwrup_seq_chk #(
  .MR_BL(MR_BL), .MR_BT(MR_BT), .MR_CL(MR_CL)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .done_o  (done_o),
  .cke_o   (cke_o),
  .cs_n_o  (cs_n_o),
  .ras_n_o (ras_n_o),
  .cas_n_o (cas_n_o),
  .we_n_o  (we_n_o),
  .ba_o    (ba_o),
  .addr_o  (addr_o)
);

// File: tb/test_ddr_pwrup_seq.sv
module test_ddr_pwrup_seq;

  // Instance A: default settings (lock time dominates)
  localparam int A_S = 40, A_TRP = 3, A_TMRD = 2, A_TRFC = 12, A_LOCK = 200;
  localparam logic [2:0] A_BL = 3'b010, A_CL = 3'b010;
  localparam logic       A_BT = 1'b0;
  // Instance B: short lock (final mode gap dominates)
  localparam int B_S = 5, B_TRP = 2, B_TMRD = 3, B_TRFC = 7, B_LOCK = 4;
  localparam logic [2:0] B_BL = 3'b011, B_CL = 3'b011;
  localparam logic       B_BT = 1'b1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  always #5 clk = ~clk;

  logic        a_done, a_cke, a_cs, a_ras, a_cas, a_we;
  logic [1:0]  a_ba;
  logic [11:0] a_addr;
  logic        b_done, b_cke, b_cs, b_ras, b_cas, b_we;
  logic [1:0]  b_ba;
  logic [11:0] b_addr;

  ddr_pwrup_seq i_ddr_pwrup_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .done_o(a_done), .cke_o(a_cke),
    .cs_n_o(a_cs), .ras_n_o(a_ras), .cas_n_o(a_cas), .we_n_o(a_we),
    .ba_o(a_ba), .addr_o(a_addr));

  ddr_pwrup_seq #(
    .SETTLE_CYC(B_S), .TRP_CYC(B_TRP), .TMRD_CYC(B_TMRD), .TRFC_CYC(B_TRFC),
    .DLL_LOCK_CYC(B_LOCK), .MR_BL(B_BL), .MR_BT(B_BT), .MR_CL(B_CL)
  ) i_ddr_pwrup_seq_short (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .done_o(b_done), .cke_o(b_cke),
    .cs_n_o(b_cs), .ras_n_o(b_ras), .cas_n_o(b_cas), .we_n_o(b_we),
    .ba_o(b_ba), .addr_o(b_addr));

  wire [19:0] a_word = {a_done, a_cke, a_cs, a_ras, a_cas, a_we, a_ba, a_addr};
  wire [19:0] b_word = {b_done, b_cke, b_cs, b_ras, b_cas, b_we, b_ba, b_addr};

  int  checks = 0;
  int  errors = 0;
  bit  finished = 0;
  bit  run = 0;
  int  t = 0;
  int  obs_t[2][8];
  int  obs_c[2][8];
  int  obs_n[2];

  // 0: no command; 1..7: the seven commands in program order
  function automatic int ev_code(int s, int trp, int tmrd, int trfc, int tt);
    int p1 = s;
    int e  = p1 + trp;
    int m1 = e + tmrd;
    int p2 = m1 + tmrd;
    int a1 = p2 + trp;
    int a2 = a1 + trfc;
    int m2 = a2 + trfc;
    if (tt == p1) return 1;
    if (tt == e)  return 2;
    if (tt == m1) return 3;
    if (tt == p2) return 4;
    if (tt == a1) return 5;
    if (tt == a2) return 6;
    if (tt == m2) return 7;
    return 0;
  endfunction

  function automatic int done_at(int s, int trp, int tmrd, int trfc, int lock);
    int m1 = s + trp + tmrd;
    int m2 = m1 + tmrd + trp + 2 * trfc;
    int x  = m2 + tmrd;
    int y  = m1 + lock;
    return (x > y) ? x : y;
  endfunction

  function automatic logic [19:0] exp_word(int s, int trp, int tmrd, int trfc, int lock,
      logic [2:0] bl, logic bt, logic [2:0] cl, bit r, int tt);
    logic [3:0]  c  = 4'b0111;
    logic [1:0]  ba = 2'b00;
    logic [11:0] ad = 12'd0;
    int ev;
    if (!r) return {1'b0, 1'b0, 4'b1111, 2'b00, 12'd0};
    ev = ev_code(s, trp, tmrd, trfc, tt);
    case (ev)
      1, 4: begin c = 4'b0010; ad[10] = 1'b1; end
      2:    begin c = 4'b0000; ba = 2'b01; end
      3:    begin c = 4'b0000; ad = {3'b000, 1'b1, 1'b0, cl, bt, bl}; end
      7:    begin c = 4'b0000; ad = {3'b000, 1'b0, 1'b0, cl, bt, bl}; end
      5, 6: c = 4'b0001;
      default: ;
    endcase
    return {(tt >= done_at(s, trp, tmrd, trfc, lock)), 1'b1, c, ba, ad};
  endfunction

  function automatic string tag_of(int s, int trp, int tmrd, int trfc, bit r, int tt,
      logic [19:0] diff);
    int ev;
    if (diff == 20'h80000) return "R9";
    if (!r) return "R1";
    ev = ev_code(s, trp, tmrd, trfc, tt);
    if (ev == 1) return "R2";
    if (ev == 2) return "R6";
    if (ev == 3 || ev == 7) return "R7";
    if (ev == 5 || ev == 6) return "R5";
    if (ev == 4) return "R4";
    return "R8";
  endfunction

  // observed command code from pins
  function automatic int obs_code(logic [19:0] w);
    if (w[17:14] == 4'b0010) return 1;
    if (w[17:14] == 4'b0000 && w[13:12] == 2'b01) return 2;
    if (w[17:14] == 4'b0000) return 3;
    if (w[17:14] == 4'b0001) return 5;
    return 0;
  endfunction

  task automatic cmp(int k, logic [19:0] got, logic [19:0] exp, string tg);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s dut%0d t=%0d got=%05h exp=%05h", tg, k, t, got, exp);
    end
  endtask

  task automatic check_int(string tg, int k, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s dut%0d got=%0d exp=%0d", tg, k, got, exp);
    end
  endtask

  // R3 and R4 and R10: order, spacing and done time of one completed program
  task automatic check_program(int k, int trp, int tmrd, int trfc);
    int want_c[7] = '{1, 2, 3, 1, 5, 5, 3};
    int gap[6];
    gap = '{trp, tmrd, tmrd, trp, trfc, trfc};
    check_int("R3 count", k, obs_n[k], 7);
    for (int i = 0; i < 7; i++) begin
      if (i < obs_n[k]) check_int("R3 order", k, obs_c[k][i], want_c[i]);
    end
    for (int i = 0; i < 6; i++) begin
      if (i + 1 < obs_n[k]) check_int("R4 spacing", k, obs_t[k][i+1] - obs_t[k][i], gap[i]);
    end
  endtask

  task automatic step(bit st, bit rs);
    logic [19:0] ea, eb;
    @(negedge clk);
    ea = exp_word(A_S, A_TRP, A_TMRD, A_TRFC, A_LOCK, A_BL, A_BT, A_CL, run, t);
    eb = exp_word(B_S, B_TRP, B_TMRD, B_TRFC, B_LOCK, B_BL, B_BT, B_CL, run, t);
    cmp(0, a_word, ea, tag_of(A_S, A_TRP, A_TMRD, A_TRFC, run, t, a_word ^ ea));
    cmp(1, b_word, eb, tag_of(B_S, B_TRP, B_TMRD, B_TRFC, run, t, b_word ^ eb));
    if (run) begin
      if (obs_code(a_word) != 0 && !a_cs && obs_n[0] < 8) begin
        obs_t[0][obs_n[0]] = t; obs_c[0][obs_n[0]] = obs_code(a_word); obs_n[0]++;
      end
      if (obs_code(b_word) != 0 && !b_cs && obs_n[1] < 8) begin
        obs_t[1][obs_n[1]] = t; obs_c[1][obs_n[1]] = obs_code(b_word); obs_n[1]++;
      end
      if (t == done_at(A_S, A_TRP, A_TMRD, A_TRFC, A_LOCK)) begin
        check_program(0, A_TRP, A_TMRD, A_TRFC);
        check_int("R10 R9 done edge", 0, a_done ? t : -1, t);
      end
      if (t == done_at(B_S, B_TRP, B_TMRD, B_TRFC, B_LOCK)) begin
        check_program(1, B_TRP, B_TMRD, B_TRFC);
        check_int("R10 R9 done edge", 1, b_done ? t : -1, t);
      end
    end
    rst_n = rs;
    start = st;
    if (!rs) run = 0;
    else if (run) t++;
    else if (st) begin
      run = 1; t = 0; obs_n[0] = 0; obs_n[1] = 0;
    end
  endtask

  initial begin
    obs_n[0] = 0; obs_n[1] = 0;
    repeat (4) step(0, 0);            // R1 reset state
    repeat (5) step(0, 1);            // R1 idle without start
    step(1, 1);                       // R2 launch
    repeat (20) step(0, 1);
    step(1, 1);                       // R10 start while running
    repeat (240) step(0, 1);          // through done of both instances
    step(1, 1);                       // R10 start after done
    repeat (10) step(0, 1);
    repeat (2) step(0, 0);            // reset clears done (R1)
    step(1, 1);
    repeat (30) step(0, 1);
    repeat (3) step(0, 0);            // reset in mid-program
    repeat (3) step(0, 1);
    step(1, 1);
    repeat (270) step(0, 1);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule